// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Message-Signalled Delivery

This block folds the pending-and-enabled vectors of eleven second-level interrupt groups into one 32-bit master interrupt register. It then asks the host delivery logic to send a message-signalled interrupt. Each second-level group presents a 32-bit vector that is already its status ANDed with its enables. One or two slices of that vector drive a summary bit of the master register. Bit 31 of the master register is the only bit software can write, and it acts as the global enable.

The master register is not recomputed every cycle. The leaf logic pulses a recheck strobe whenever one of its own enable, clear, mask or injection operations completes. A write to the master register also counts as a recheck. A recheck made while the global enable is clear does nothing. When the enable is set and the re-evaluated summary is non-zero, the block raises a request that carries the capability address and data. The request is held until the delivery side accepts it, and further triggers fold into it while it waits.

Top module: `irq_master_agg`

## Requirements
- R1: After synchronous reset the master register reads zero, and neither a request nor an error is present.
- R2: A master write changes only bit 31 (the global enable). Bits 30:0 of the written value are ignored, and the summary bits keep the values that evaluation produces.
- R3: Leaf index to summary bit map (leaf vectors are 32 bits each): leaf 0 bits 15:0 drive bit 0 and bits 31:16 drive bit 1. Leaf 1 bits 15:0 drive bit 2 and bits 31:16 drive bit 3. Leaf 2 bits 15:0 drive bit 4, and leaf 3 bits 15:0 drive bit 6. The full vectors of leaves 4, 5, 6, 7, 8, 9 and 10 drive bits 16, 17, 18, 20, 22, 23 and 30. All other summary bits read zero.
- R4: On an evaluation, a summary bit becomes 1 when its masked leaf slice is non-zero and 0 when the slice is zero. The new value is visible one cycle after the trigger.
- R5: An evaluation happens only in a cycle with the recheck strobe or a master write. In any other cycle the summary bits hold, whatever the leaf inputs do.
- R6: When the enable that results from the cycle is 0, a trigger neither updates the summary nor requests an interrupt.
- R7: When the resulting enable is 1 and the newly evaluated summary bits 30:0 are non-zero, a request is raised in the following cycle.
- R8: A trigger that would raise a request raises none when bit 0 of the capability control word is 0. When any of control bits 15:1 is set, it raises none and pulses the error output for one cycle instead.
- R9: The request stays high until it is accepted by ready. A new request made while one is waiting, or in the cycle it is accepted, keeps the request high and replaces its address and data with the capability fields of the new trigger.
- R10: A master write that changes the enable from 0 to 1 while a leaf slice is non-zero produces a request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| leaf_pend | input | 352 | Eleven leaf pending-and-enabled vectors; leaf i at bits 32*i+31:32*i |
| recheck | input | 1 | Strobe: a leaf operation completed, re-evaluate |
| mst_wr_en | input | 1 | Master register write strobe |
| mst_wr_data | input | 32 | Master register write value |
| mst_rd_data | output | 32 | Master register read value |
| msi_ctrl | input | 16 | Capability control word |
| msi_addr | input | 32 | Capability message address |
| msi_data | input | 16 | Capability message data |
| msi_ready | input | 1 | Delivery side accepts the request |
| msi_req | output | 1 | Interrupt request |
| msi_req_addr | output | 32 | Address of the request |
| msi_req_data | output | 16 | Data of the request |
| msi_cfg_err | output | 1 | One-cycle pulse: request rejected by an unsupported control word |

## Verification
Two things can land in the same cycle: the delivery side accepts a waiting request, and a new trigger fires. A master write can also coincide with a recheck strobe and change the enable in that same cycle. The bench provokes both by holding a long random phase with frequent rechecks, frequent enable writes and a ready that toggles pseudo-randomly. A behavioural model built from the requirement text is compared with the outputs every cycle. In a collision cycle the request must stay high and carry the new address and data. A write that clears the enable must also suppress the evaluation that a recheck in the same cycle would otherwise make.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int LEAF_W   = 32;
    localparam int N_LEAF   = 11;
    localparam int N_MAP    = 13;
    localparam int MST_W    = 32;
    localparam int EN_BIT   = 31;
    localparam int SUM_W    = EN_BIT;
    localparam int CTRL_W   = 16;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 16;

    typedef struct packed {
        logic [3:0]        src;
        logic [4:0]        dst;
        logic [LEAF_W-1:0] mask;
    } map_ent_t;

    typedef struct packed {
        logic             en;
        logic [SUM_W-1:0] sum;
    } mst_reg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } msi_msg_t;

    localparam logic [LEAF_W-1:0] LO_HALF = 32'h0000_ffff;
    localparam logic [LEAF_W-1:0] HI_HALF = 32'hffff_0000;
    localparam logic [LEAF_W-1:0] ALL_W   = 32'hffff_ffff;

    function automatic map_ent_t map_entry(input int idx);
        map_ent_t e;
        case (idx)
            0:  e = '{src: 4'd0,  dst: 5'd0,  mask: LO_HALF};
            1:  e = '{src: 4'd0,  dst: 5'd1,  mask: HI_HALF};
            2:  e = '{src: 4'd1,  dst: 5'd2,  mask: LO_HALF};
            3:  e = '{src: 4'd1,  dst: 5'd3,  mask: HI_HALF};
            4:  e = '{src: 4'd2,  dst: 5'd4,  mask: LO_HALF};
            5:  e = '{src: 4'd3,  dst: 5'd6,  mask: LO_HALF};
            6:  e = '{src: 4'd4,  dst: 5'd16, mask: ALL_W};
            7:  e = '{src: 4'd5,  dst: 5'd17, mask: ALL_W};
            8:  e = '{src: 4'd6,  dst: 5'd18, mask: ALL_W};
            9:  e = '{src: 4'd7,  dst: 5'd20, mask: ALL_W};
            10: e = '{src: 4'd8,  dst: 5'd22, mask: ALL_W};
            11: e = '{src: 4'd9,  dst: 5'd23, mask: ALL_W};
            default: e = '{src: 4'd10, dst: 5'd30, mask: ALL_W};
        endcase
        return e;
    endfunction

    function automatic logic ctrl_unsupported(input logic [CTRL_W-1:0] c);
        return |c[CTRL_W-1:1];
    endfunction

endpackage

// File: rtl/irq_summary_map.sv
module irq_summary_map
    import irq_agg_pkg::*;
#(
    parameter int NUM_LEAF = N_LEAF,
    localparam int PEND_W  = NUM_LEAF * LEAF_W
) (
    input  logic [PEND_W-1:0] pend,
    output logic [SUM_W-1:0]  sum
);

    logic [N_MAP-1:0] hit;

    for (genvar m = 0; m < N_MAP; m++) begin : g_ent
        localparam map_ent_t ENT = map_entry(m);
        if (int'(ENT.src) < NUM_LEAF) begin : g_live
            assign hit[m] = |(pend[int'(ENT.src)*LEAF_W +: LEAF_W] & ENT.mask);
        end else begin : g_absent
            assign hit[m] = 1'b0;
        end
    end

    for (genvar b = 0; b < SUM_W; b++) begin : g_bit
        always_comb begin
            sum[b] = 1'b0;
            for (int m = 0; m < N_MAP; m++) begin
                if (int'(map_entry(m).dst) == b) begin
                    sum[b] = sum[b] | hit[m];
                end
            end
        end
    end

endmodule

// File: rtl/irq_master_reg.sv
module irq_master_reg
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             recheck,
    input  logic             wr_en,
    input  logic [MST_W-1:0] wr_data,
    input  logic [SUM_W-1:0] sum_in,
    output mst_reg_t         q,
    output logic             fire
);

    logic trig;
    logic en_next;
    logic upd;

    assign trig    = recheck | wr_en;
    assign en_next = wr_en ? wr_data[EN_BIT] : q.en;
    assign upd     = trig & en_next;
    assign fire    = upd & (|sum_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.en <= en_next;
            if (upd) begin
                q.sum <= sum_in;
            end
        end
    end

    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(recheck || wr_en) |=> $stable(q.sum)); // R5

    AST_EN_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q.en == $past(wr_data[EN_BIT]))); // R2

    AST_OFF_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[EN_BIT]) |=> $stable(q.sum)); // R6

endmodule

// File: rtl/irq_msi_gen.sv
module irq_msi_gen
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              ready,
    output logic              req,
    output msi_msg_t          msg,
    output logic              err
);

    logic bad_fmt;
    logic go;

    assign bad_fmt = ctrl_unsupported(ctrl);
    assign go      = fire & ~bad_fmt & ctrl[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            msg <= '0;
            err <= 1'b0;
        end else begin
            err <= fire & bad_fmt;
            if (go) begin
                req      <= 1'b1;
                msg.addr <= addr;
                msg.data <= data;
            end else if (req && ready) begin
                req <= 1'b0;
            end
        end
    end

    AST_REQ_WAITS: assert property (@(posedge clk) disable iff (rst)
        (req && !ready) |=> req); // R9

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(ctrl[CTRL_W-1:1]) != '0)); // R8

    AST_ERR_NO_NEW_REQ: assert property (@(posedge clk) disable iff (rst)
        (err && !$past(req)) |-> !req); // R8

endmodule

// File: rtl/irq_master_agg.sv
module irq_master_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_LEAF = N_LEAF,
    localparam int PEND_W  = NUM_LEAF * LEAF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PEND_W-1:0] leaf_pend,
    input  logic              recheck,
    input  logic              mst_wr_en,
    input  logic [MST_W-1:0]  mst_wr_data,
    output logic [MST_W-1:0]  mst_rd_data,
    input  logic [CTRL_W-1:0] msi_ctrl,
    input  logic [ADDR_W-1:0] msi_addr,
    input  logic [DATA_W-1:0] msi_data,
    input  logic              msi_ready,
    output logic              msi_req,
    output logic [ADDR_W-1:0] msi_req_addr,
    output logic [DATA_W-1:0] msi_req_data,
    output logic              msi_cfg_err
);

    logic [SUM_W-1:0] sum_now;
    mst_reg_t         mreg;
    logic             fire;
    msi_msg_t         msg;

    irq_summary_map #(.NUM_LEAF(NUM_LEAF)) u_map (
        .pend (leaf_pend),
        .sum  (sum_now)
    );

    irq_master_reg u_mreg (
        .clk     (clk),
        .rst     (rst),
        .recheck (recheck),
        .wr_en   (mst_wr_en),
        .wr_data (mst_wr_data),
        .sum_in  (sum_now),
        .q       (mreg),
        .fire    (fire)
    );

    irq_msi_gen u_msi (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .ctrl  (msi_ctrl),
        .addr  (msi_addr),
        .data  (msi_data),
        .ready (msi_ready),
        .req   (msi_req),
        .msg   (msg),
        .err   (msi_cfg_err)
    );

    assign mst_rd_data  = mreg;
    assign msi_req_addr = msg.addr;
    assign msi_req_data = msg.data;

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mst_rd_data == '0 && !msi_req && !msi_cfg_err)); // R1

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        ($rose(msi_req) && !$past(rst)) |-> (mst_rd_data[EN_BIT] && (|mst_rd_data[SUM_W-1:0]))); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mst_rd_data[5] == 1'b0) && (mst_rd_data[15:7] == '0) && (mst_rd_data[19] == 1'b0)
        && (mst_rd_data[21] == 1'b0) && (mst_rd_data[29:24] == '0)); // R3

endmodule

// File: tb/irq_master_agg_bench.sv
module irq_master_agg_bench;

    localparam int NL = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] leaf [NL];
    logic [NL*32-1:0] leaf_flat;
    logic        recheck = 1'b0;
    logic        mst_wr_en = 1'b0;
    logic [31:0] mst_wr_data = '0;
    logic [31:0] mst_rd_data;
    logic [15:0] msi_ctrl = 16'h0001;
    logic [31:0] msi_addr = 32'hfee0_0000;
    logic [15:0] msi_data = 16'h0040;
    logic        msi_ready = 1'b0;
    logic        msi_req;
    logic [31:0] msi_req_addr;
    logic [15:0] msi_req_data;
    logic        msi_cfg_err;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NL; i++) leaf_flat[i*32 +: 32] = leaf[i];
    end

    irq_master_agg u_irq_master_agg (
        .clk(clk), .rst(rst), .leaf_pend(leaf_flat), .recheck(recheck),
        .mst_wr_en(mst_wr_en), .mst_wr_data(mst_wr_data), .mst_rd_data(mst_rd_data),
        .msi_ctrl(msi_ctrl), .msi_addr(msi_addr), .msi_data(msi_data),
        .msi_ready(msi_ready), .msi_req(msi_req), .msi_req_addr(msi_req_addr),
        .msi_req_data(msi_req_data), .msi_cfg_err(msi_cfg_err)
    );

    // reference model state
    logic        m_en = 0, m_req = 0, m_err = 0;
    logic [30:0] m_sum = '0;
    logic [31:0] m_addr = '0;
    logic [15:0] m_data = '0;
    bit          started = 0;
    int          n_cmp = 0, n_bad = 0;
    string       tag = "R1";

    function automatic logic [30:0] ref_sum();
        logic [30:0] s = '0;
        s[0]  = leaf[0][15:0]  != 0;
        s[1]  = leaf[0][31:16] != 0;
        s[2]  = leaf[1][15:0]  != 0;
        s[3]  = leaf[1][31:16] != 0;
        s[4]  = leaf[2][15:0]  != 0;
        s[6]  = leaf[3][15:0]  != 0;
        s[16] = leaf[4] != 0;
        s[17] = leaf[5] != 0;
        s[18] = leaf[6] != 0;
        s[20] = leaf[7] != 0;
        s[22] = leaf[8] != 0;
        s[23] = leaf[9] != 0;
        s[30] = leaf[10] != 0;
        return s;
    endfunction

    always @(posedge clk) begin
        logic en_n, fire;
        logic [30:0] s;
        started <= 1'b1;
        if (rst) begin
            m_en = 0; m_sum = '0; m_req = 0; m_err = 0; m_addr = '0; m_data = '0;
        end else begin
            en_n = mst_wr_en ? mst_wr_data[31] : m_en;
            fire = 0;
            if ((recheck || mst_wr_en) && en_n) begin
                s = ref_sum();
                m_sum = s;
                fire = (s != 0);
            end
            m_en = en_n;
            m_err = fire && (msi_ctrl[15:1] != 0);
            if (fire && msi_ctrl[15:1] == 0 && msi_ctrl[0]) begin
                m_req = 1; m_addr = msi_addr; m_data = msi_data;
            end else if (m_req && msi_ready) begin
                m_req = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            n_cmp++;
            if (mst_rd_data !== {m_en, m_sum}) begin
                n_bad++;
                $display("FAIL %s master reg: got %h expected %h", tag, mst_rd_data, {m_en, m_sum});
            end
            if (msi_req !== m_req) begin
                n_bad++;
                $display("FAIL %s request: got %b expected %b", tag, msi_req, m_req);
            end
            if (m_req && (msi_req_addr !== m_addr || msi_req_data !== m_data)) begin
                n_bad++;
                $display("FAIL %s message: got %h/%h expected %h/%h", tag,
                         msi_req_addr, msi_req_data, m_addr, m_data);
            end
            if (msi_cfg_err !== m_err) begin
                n_bad++;
                $display("FAIL %s error pulse: got %b expected %b", tag, msi_cfg_err, m_err);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_recheck();
        recheck = 1; step(); recheck = 0;
    endtask

    task automatic mwrite(logic [31:0] v);
        mst_wr_en = 1; mst_wr_data = v; step(); mst_wr_en = 0;
    endtask

    task automatic clear_leaves();
        for (int i = 0; i < NL; i++) leaf[i] = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired during %s", tag);
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        clear_leaves();
        step(3);
        rst = 0;
        tag = "R1"; step(2);

        // R6: enable clear, triggers do nothing
        tag = "R6";
        leaf[4] = 32'h10; pulse_recheck(); step(2);
        mwrite(32'h7fff_ffff); step(2);

        // R10 / R2: enable rises with a pending leaf, low bits ignored
        tag = "R10"; msi_ready = 0;
        mwrite(32'hffff_ffff); step(3);
        tag = "R9"; msi_ready = 1; step(1); msi_ready = 0; step(2);

        // R3 / R4: each slice, lowest and highest bit of its mask
        tag = "R3";
        msi_ready = 1;
        for (int g = 0; g < NL; g++) begin
            for (int k = 0; k < 4; k++) begin
                clear_leaves();
                leaf[g] = 32'h1 << (k * 8 + (k % 2) * 7);
                pulse_recheck(); step(2);
            end
        end
        tag = "R4"; clear_leaves(); pulse_recheck(); step(2);

        // R5: leaves move with no trigger
        tag = "R5"; leaf[9] = 32'h8; step(4); leaf[9] = 0; step(2);

        // R8: capability control gating
        tag = "R8";
        leaf[0] = 1; msi_ctrl = 16'h0000; pulse_recheck(); step(2);
        msi_ctrl = 16'h0003; pulse_recheck(); step(2);
        msi_ctrl = 16'h8001; pulse_recheck(); step(2);
        msi_ctrl = 16'h0001;

        // R9: coalescing while waiting
        tag = "R9"; msi_ready = 0;
        msi_addr = 32'hfee0_1000; pulse_recheck(); step(1);
        msi_addr = 32'hfee0_2000; msi_data = 16'h0055; pulse_recheck(); step(2);
        msi_ready = 1; pulse_recheck(); step(2);

        // R7: random mixed traffic
        tag = "R7";
        lf = 32'h1234_5679;
        for (int c = 0; c < 3000; c++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            for (int i = 0; i < NL; i++)
                leaf[i] = (lf[i+8] && lf[i+19]) ? (32'h1 << ((lf[4:0] + 5'(i * 3)))) : '0;
            recheck   = lf[0];
            mst_wr_en = (lf[3:1] == 3'b000);
            mst_wr_data = {lf[30], lf[31:1]};
            msi_ready = lf[5] | lf[6];
            msi_ctrl  = (lf[15:9] == 0) ? 16'h0002 : (lf[22:20] == 0 ? 16'h0000 : 16'h0001);
            msi_addr  = {lf[27:0], 4'h0};
            msi_data  = lf[31:16];
            step();
        end
        recheck = 0; mst_wr_en = 0; msi_ready = 1;
        step(3);
        finish_run();
    end

endmodule